// File: doc/BRIEF.md
# Saturating Dual-Width Shift Unit

This block shifts a 16-bit or 32-bit operand by an amount supplied with each request. It offers four shift kinds: logical left, logical right, arithmetic left and arithmetic right. The operand and the count travel together on one valid/ready request channel. The result travels on a valid/ready response channel together with two flags. One flag marks arithmetic-left overflow. The other marks a single-word count that lies outside the accepted range.

Counts saturate and never wrap. In single-word mode, any count from 16 to 31 acts as a count of 16. In double-word mode, any count above 32 acts as a count of 32, and the whole 15-bit count field is accepted. So a full-width logical shift gives zero, and a full-width arithmetic right shift gives sign copies in every position.

The parameter `REGISTERED` selects between two forms. When it is set, a single output register sits between the two channels and honours back-pressure. When it is clear, the unit is purely combinational and the handshake passes straight through. Back-pressure rules: a request is taken on a clock edge where `in_valid` and `in_ready` are both high. A response is consumed on an edge where `out_valid` and `out_ready` are both high. While a response waits with `out_ready` low, it holds steady and no new request is taken.

Top module: `sat_shift_unit`

## Requirements
- R1: Operation code 2'b00 is a logical left shift: the result is the operand moved left by the effective count, with zeros filled in at the bottom.
- R2: Operation code 2'b01 is a logical right shift with zeros filled in at the top.
- R3: Operation code 2'b11 is an arithmetic right shift: vacated top positions take the sign bit, so a full-width shift gives all sign copies.
- R4: Operation code 2'b10 is an arithmetic left shift. Its result equals the logical left shift. `out_ovf` is set exactly when the signed operand multiplied by 2^(effective count) does not fit the active width. A nonzero operand shifted by the full width therefore always overflows.
- R5: When `in_dbl` is 0, only operand bits 15:0 are used and result bits 31:16 are zero. Counts 16 through 31 give the same result and flag as a count of 16.
- R6: When `in_dbl` is 0 and the count is above 31, `out_oor` is 1, the result is all zeros and `out_ovf` is 0.
- R7: When `in_dbl` is 1, every count from 0 to 32767 is accepted and `out_oor` stays 0. Counts above 32 give the same output as a count of 32.
- R8: `out_ovf` is 0 for every operation code other than 2'b10.
- R9: With `REGISTERED`=1, an accepted request appears on the response channel on the clock edge that accepts it. `out_valid` is visible in the following cycle. A response held by `out_ready`=0 keeps its value. `in_ready` is high exactly when no response is held or the held one is being consumed.
- R10: With `REGISTERED`=1, a synchronous active-high `rst` clears `out_valid`, the result and both flags.
- R11: With `REGISTERED`=0, `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and the outputs reflect the current request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| in_operand | input | 32 | Value to shift (bits 15:0 only in single-word mode) |
| in_count | input | 15 | Run-time shift count |
| in_dbl | input | 1 | 1 selects 32-bit mode, 0 selects 16-bit mode |
| in_op | input | 2 | Shift kind: 00 LSL, 01 LSR, 10 ASL, 11 ASR |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Consumer takes the response |
| out_result | output | 32 | Shifted value |
| out_ovf | output | 1 | Arithmetic-left overflow |
| out_oor | output | 1 | Single-word count above 31 |

## Verification
The bench builds two copies of the unit that share one request stream, both with the default 16-bit word and 15-bit count. The copy named `dut` uses `REGISTERED`=1. Its response side gets random back-pressure, which exercises holding, stalling and back-to-back acceptance. The second copy uses `REGISTERED`=0 with `out_ready` tied high, so every request is also checked in the same cycle against the model. With the 15-bit count, the bench can apply the largest accepted double-word count of 32767, the saturation points at 16, 31, 32 and 33, and single-word counts past 31.

// File: rtl/sat_shift_pkg.sv
package sat_shift_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASL = 2'b10,
    SH_ASR = 2'b11
  } shift_op_e;

  function automatic logic op_is_left(shift_op_e op);
    return (op == SH_LSL) || (op == SH_ASL);
  endfunction

  function automatic logic op_is_arith(shift_op_e op);
    return (op == SH_ASL) || (op == SH_ASR);
  endfunction
endpackage

// File: rtl/sat_shift_count_clamp.sv
// Turns the raw count into an effective amount limited to the active width
// and flags single-word counts beyond the accepted range.
module sat_shift_count_clamp #(
  parameter int SGL_W = 16,
  parameter int CNT_W = 15,
  parameter int AMT_W = 6
) (
  input  logic [CNT_W-1:0] raw_count,
  input  logic             dbl,
  output logic [AMT_W-1:0] amt,
  output logic             oor
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DBL_W     = 2 * SGL_W;
  localparam int SGL_LIMIT = 2 * SGL_W - 1;

  logic sgl_sat, dbl_sat;

  always_comb begin
    sgl_sat = (raw_count >= CNT_W'(SGL_W));
    dbl_sat = (raw_count >= CNT_W'(DBL_W));
    oor     = !dbl && (raw_count > CNT_W'(SGL_LIMIT));
    if (dbl) begin
      amt = dbl_sat ? AMT_W'(DBL_W) : AMT_W'(raw_count);
    end else begin
      amt = sgl_sat ? AMT_W'(SGL_W) : AMT_W'(raw_count);
    end
  end
endmodule

// File: rtl/sat_shift_barrel.sv
// Log-depth shifter. Left shifts reuse the right-shift network through bit
// reversal; the amount is at most W, which the top stage turns into a full fill.
module sat_shift_barrel #(
  parameter int W = 16
) (
  input  logic [W-1:0]       opnd,
  input  logic [$clog2(W):0] amt,
  input  logic               left,
  input  logic               arith,
  output logic [W-1:0]       result
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int STG = $clog2(W) + 1;

  logic         fill;
  logic [W-1:0] pre;
  logic [W-1:0] stg [0:STG];

  always_comb begin
    fill = arith && !left && opnd[W-1];
    for (int i = 0; i < W; i++) begin
      pre[i] = left ? opnd[W-1-i] : opnd[i];
    end
  end

  assign stg[0] = pre;

  for (genvar k = 0; k < STG; k++) begin : g_stage
    localparam int SH = 1 << k;
    if (SH >= W) begin : g_full
      assign stg[k+1] = amt[k] ? {W{fill}} : stg[k];
    end else begin : g_part
      assign stg[k+1] = amt[k] ? {{SH{fill}}, stg[k][W-1:SH]} : stg[k];
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      result[i] = left ? stg[STG][W-1-i] : stg[STG][i];
    end
  end
endmodule

// File: rtl/sat_shift_ovf.sv
// Overflow for arithmetic left: the shift loses information once the amount
// reaches the length of the run of bits at the top that equal the sign.
module sat_shift_ovf #(
  parameter int W = 16
) (
  input  logic [W-1:0]       opnd,
  input  logic [$clog2(W):0] amt,
  input  logic               enable,
  output logic               ovf
);
  timeunit 1ns;
  timeprecision 1ps;

  int   lead;
  logic found;

  always_comb begin
    lead  = W;
    found = 1'b0;
    for (int i = W - 2; i >= 0; i--) begin
      if (!found && (opnd[i] != opnd[W-1])) begin
        lead  = W - 1 - i;
        found = 1'b1;
      end
    end
    ovf = enable && (opnd != '0) && (int'(amt) >= lead);
  end
endmodule

// File: rtl/sat_shift_out.sv
// Response stage: one holding register with back-pressure, or a wire-through.
module sat_shift_out #(
  parameter int DATA_W     = 34,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  timeunit 1ns;
  timeprecision 1ps;

  if (REGISTERED) begin : g_reg
    logic              vld_q;
    logic [DATA_W-1:0] data_q;

    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign out_data  = data_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q  <= 1'b0;
        data_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) begin
          data_q <= in_data;
        end
      end
    end
  end else begin : g_wire
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end
endmodule

// File: rtl/sat_shift_unit.sv
module sat_shift_unit
  import sat_shift_pkg::*;
#(
  parameter int SGL_W      = 16,
  parameter int CNT_W      = 15,
  parameter bit REGISTERED = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2*SGL_W-1:0] in_operand,
  input  logic [CNT_W-1:0]   in_count,
  input  logic               in_dbl,
  input  logic [1:0]         in_op,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [2*SGL_W-1:0] out_result,
  output logic               out_ovf,
  output logic               out_oor
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DBL_W  = 2 * SGL_W;
  localparam int SGL_AW = $clog2(SGL_W) + 1;
  localparam int DBL_AW = $clog2(DBL_W) + 1;
  localparam int PKT_W  = DBL_W + 2;

  shift_op_e op;
  logic      left, arith, asl;
  assign op    = shift_op_e'(in_op);
  assign left  = op_is_left(op);
  assign arith = op_is_arith(op);
  assign asl   = (op == SH_ASL);

  logic [DBL_AW-1:0] amt;
  logic              oor;

  sat_shift_count_clamp #(
    .SGL_W(SGL_W), .CNT_W(CNT_W), .AMT_W(DBL_AW)
  ) u_clamp (
    .raw_count(in_count), .dbl(in_dbl), .amt(amt), .oor(oor)
  );

  logic [SGL_W-1:0] res_s;
  logic [DBL_W-1:0] res_d;
  logic             ovf_s, ovf_d;

  sat_shift_barrel #(.W(SGL_W)) u_bar_s (
    .opnd(in_operand[SGL_W-1:0]), .amt(amt[SGL_AW-1:0]),
    .left(left), .arith(arith), .result(res_s)
  );

  sat_shift_barrel #(.W(DBL_W)) u_bar_d (
    .opnd(in_operand), .amt(amt), .left(left), .arith(arith), .result(res_d)
  );

  sat_shift_ovf #(.W(SGL_W)) u_ovf_s (
    .opnd(in_operand[SGL_W-1:0]), .amt(amt[SGL_AW-1:0]), .enable(asl), .ovf(ovf_s)
  );

  sat_shift_ovf #(.W(DBL_W)) u_ovf_d (
    .opnd(in_operand), .amt(amt), .enable(asl), .ovf(ovf_d)
  );

  logic [DBL_W-1:0] res_sel;
  logic             ovf_sel;

  always_comb begin
    if (oor) begin
      res_sel = '0;
      ovf_sel = 1'b0;
    end else if (in_dbl) begin
      res_sel = res_d;
      ovf_sel = ovf_d;
    end else begin
      res_sel = {{(DBL_W-SGL_W){1'b0}}, res_s};
      ovf_sel = ovf_s;
    end
  end

  logic [PKT_W-1:0] pkt_in, pkt_out;
  assign pkt_in = {oor, ovf_sel, res_sel};

  sat_shift_out #(.DATA_W(PKT_W), .REGISTERED(REGISTERED)) u_out (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(pkt_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(pkt_out)
  );

  assign out_result = pkt_out[DBL_W-1:0];
  assign out_ovf    = pkt_out[DBL_W];
  assign out_oor    = pkt_out[DBL_W+1];
endmodule

// File: rtl/sat_shift_unit_sva.sv
module sat_shift_unit_sva #(
  parameter int SGL_W      = 16,
  parameter bit REGISTERED = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic               in_dbl,
  input logic [1:0]         in_op,
  input logic               out_valid,
  input logic               out_ready,
  input logic [2*SGL_W-1:0] out_result,
  input logic               out_ovf,
  input logic               out_oor
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DBL_W = 2 * SGL_W;

  a_r6_oor_clears: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_oor |-> (out_result == '0) && !out_ovf);

  if (REGISTERED) begin : g_reg
    a_r9_accept_then_valid: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready |=> out_valid);

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_result)
                                  && $stable(out_ovf) && $stable(out_oor));

    a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready && !in_dbl |=> out_result[DBL_W-1:SGL_W] == '0);

    a_r7_dbl_in_range: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready && in_dbl |=> !out_oor);

    a_r8_ovf_asl_only: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready && (in_op != 2'b10) |=> !out_ovf);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    always @(negedge clk) begin
      if (rst_d === 1'b1) begin
        a_r10_reset_clear: assert (!out_valid && (out_result == '0) && !out_ovf && !out_oor);
      end
    end
  end else begin : g_wire
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
      in_valid && !in_dbl |-> out_result[DBL_W-1:SGL_W] == '0);

    a_r7_dbl_in_range: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_dbl |-> !out_oor);

    a_r8_ovf_asl_only: assert property (@(posedge clk) disable iff (rst)
      in_valid && (in_op != 2'b10) |-> !out_ovf);
  end
endmodule

bind sat_shift_unit sat_shift_unit_sva #(
  .SGL_W(SGL_W), .REGISTERED(REGISTERED)
) u_sva (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_dbl(in_dbl), .in_op(in_op), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_ovf(out_ovf), .out_oor(out_oor)
);

// File: tb/tb_sat_shift_unit.sv
module tb_sat_shift_unit;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_operand = '0;
  logic [14:0] in_count = '0;
  logic        in_dbl = 1'b0;
  logic [1:0]  in_op = 2'b00;
  logic        out_ready = 1'b1;
  logic        bp_en = 1'b0;
  logic        mon_en = 1'b0;

  logic        in_ready, out_valid, out_ovf, out_oor;
  logic [31:0] out_result;
  logic        c_in_ready, c_out_valid, c_ovf, c_oor;
  logic [31:0] c_result;

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic [33:0] exp;
    string       tag;
    string       otag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  sat_shift_unit #(.SGL_W(16), .CNT_W(15), .REGISTERED(1'b1)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_count(in_count), .in_dbl(in_dbl), .in_op(in_op),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_ovf(out_ovf), .out_oor(out_oor)
  );

  sat_shift_unit #(.SGL_W(16), .CNT_W(15), .REGISTERED(1'b0)) dut_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(c_in_ready),
    .in_operand(in_operand), .in_count(in_count), .in_dbl(in_dbl), .in_op(in_op),
    .out_valid(c_out_valid), .out_ready(1'b1), .out_result(c_result),
    .out_ovf(c_ovf), .out_oor(c_oor)
  );

  // Behavioural model: returns {oor, ovf, result}
  function automatic logic [33:0] ref_fn(logic [31:0] opd, int cnt, bit dbl, logic [1:0] op);
    int w, n;
    longint mask, u, sv, r, p, hi, lo;
    bit ov;
    w    = dbl ? 32 : 16;
    mask = (longint'(1) <<< w) - 1;
    u    = longint'({32'b0, opd}) & mask;
    sv   = (u >= (longint'(1) <<< (w - 1))) ? u - (longint'(1) <<< w) : u;
    if (!dbl && cnt > 31) return {1'b1, 1'b0, 32'h0};
    n  = (cnt > w) ? w : cnt;
    ov = 1'b0;
    case (op)
      2'b00, 2'b10: r = (u <<< n) & mask;
      2'b01:        r = u >> n;
      default:      r = (sv >>> n) & mask;
    endcase
    if (op == 2'b10) begin
      p  = sv <<< n;
      hi = (longint'(1) <<< (w - 1)) - 1;
      lo = -(longint'(1) <<< (w - 1));
      ov = (p > hi) || (p < lo);
    end
    return {1'b0, ov, r[31:0]};
  endfunction

  function automatic string tag_of(int cnt, bit dbl, logic [1:0] op);
    if (!dbl && cnt > 31) return "R6";
    if (dbl && cnt > 32)  return "R7";
    if (!dbl && cnt >= 16) return "R5";
    case (op)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor, a few ns before each rising edge
  always begin
    @(negedge clk);
    #3;
    if (mon_en && !rst) begin
      logic [33:0] e;
      string t, ot;
      e  = ref_fn(in_operand, int'(in_count), in_dbl, in_op);
      t  = tag_of(int'(in_count), in_dbl, in_op);
      ot = (in_op == 2'b10) ? "R4" : "R8";
      // unregistered copy
      check(c_out_valid == in_valid, "R11", "comb out_valid", 64'(c_out_valid), 64'(in_valid));
      check(c_in_ready == 1'b1, "R11", "comb in_ready", 64'(c_in_ready), 64'd1);
      if (in_valid) begin
        check(c_result == e[31:0], t, "comb result", 64'(c_result), 64'(e[31:0]));
        check(c_ovf == e[32], ot, "comb ovf", 64'(c_ovf), 64'(e[32]));
        check(c_oor == e[33], (in_dbl ? "R7" : "R6"), "comb oor", 64'(c_oor), 64'(e[33]));
      end
      // registered copy
      check(out_valid == (q.size() != 0), "R9", "out_valid", 64'(out_valid), 64'(q.size() != 0));
      check(in_ready == ((q.size() == 0) || out_ready), "R9", "in_ready",
            64'(in_ready), 64'((q.size() == 0) || out_ready));
      if (out_valid && q.size() != 0) begin
        check(out_result == q[0].exp[31:0], q[0].tag, "result", 64'(out_result), 64'(q[0].exp[31:0]));
        check(out_ovf == q[0].exp[32], q[0].otag, "ovf", 64'(out_ovf), 64'(q[0].exp[32]));
        check(out_oor == q[0].exp[33], "R6", "oor", 64'(out_oor), 64'(q[0].exp[33]));
        if (out_ready) void'(q.pop_front());
      end
      if (in_valid && in_ready) q.push_back('{e, t, ot});
    end
  end

  always @(negedge clk) out_ready <= bp_en ? ($urandom % 4 != 0) : 1'b1;

  task automatic send(logic [31:0] opd, int cnt, bit dbl, logic [1:0] op);
    @(negedge clk);
    in_valid   = 1'b1;
    in_operand = opd;
    in_count   = 15'(cnt);
    in_dbl     = dbl;
    in_op      = op;
    #3;
    while (!in_ready) begin
      @(negedge clk);
      #3;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [31:0] opds [6];
    int          cnts [11];
    opds = '{32'h8000_8001, 32'h1234_C5A7, 32'h4000_7FFF, 32'hFFFF_FFFF, 32'h0, 32'h8000_0000};
    cnts = '{0, 1, 7, 15, 16, 17, 31, 32, 33, 100, 32767};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    #3;
    // R10: state right after reset
    check(!out_valid && out_result == 0 && !out_ovf && !out_oor, "R10", "after reset",
          {30'b0, out_valid, out_ovf, out_result}, 64'd0);
    mon_en = 1'b1;

    // Directed corners, no back-pressure
    for (int o = 0; o < 4; o++)
      for (int d = 0; d < 2; d++)
        foreach (cnts[c])
          foreach (opds[v])
            send(opds[v], cnts[c], d[0], 2'(o));
    idle(3);

    // R4 single-word overflow boundary pair
    send(32'h0000_4000, 1, 1'b0, 2'b10);
    send(32'h0000_2000, 1, 1'b0, 2'b10);
    send(32'h0000_0001, 16, 1'b0, 2'b10);
    send(32'hFFFF_C000, 1, 1'b1, 2'b10);

    // Random traffic with back-pressure
    bp_en = 1'b1;
    for (int i = 0; i < 1500; i++) begin
      int c;
      c = ($urandom % 3 == 0) ? int'($urandom % 32768) : int'($urandom % 40);
      send($urandom, c, 1'($urandom), 2'($urandom));
      if ($urandom % 5 == 0) idle(1);
    end
    idle(1);

    // R10: reset while a response is held
    send(32'h0000_00F0, 2, 1'b0, 2'b00);
    @(negedge clk);
    in_valid = 1'b0;
    bp_en = 1'b0;
    rst = 1'b1;
    q.delete();
    @(negedge clk);
    rst = 1'b0;
    #3;
    check(!out_valid && out_result == 0 && !out_ovf && !out_oor, "R10", "mid-run reset",
          {30'b0, out_valid, out_ovf, out_result}, 64'd0);

    send(32'h0000_8000, 20, 1'b0, 2'b11);
    idle(4);
    finish_run();
  end
endmodule